// File: doc/BRIEF.md
# Device Status and Interrupt Shadow

This block is the local copy of one virtual I/O device's state, held next to the CPU while a slow polling host does the real work of emulating the device. The host sends commands through a narrow command port. It can load a status word, raise interrupt levels, read and clear the pending interrupt levels, and read and clear the code of the last function the CPU issued. The CPU side issues device commands. A sense command that carries the reset modifier drops the selected interrupt levels and the operation-complete flag at once, without waiting for the host.

Interrupt requests are driven straight from the level flops, so the CPU sees a request vanish on the clock edge that takes its sense-with-reset. The operation-complete flag is also kept locally. A host write can only set it, and only the CPU can clear it, so the two sides never disagree about whether a completion has been acknowledged. Every host read returns the value held before the clear in the same cycle, so a poll never misses a change.

Top module: `dev_status_shadow`

## Requirements
- R1: During and after synchronous active-low reset, `irq_req`, `cpu_dsw` and `host_rsp_data` are zero and `host_rsp_valid` is low.
- R2: Host command code 2 ORs `host_cmd_data[2:0]` into the three interrupt levels. `irq_req[i]` shows level i on the clock edge that accepts the command.
- R3: A CPU command with `cpu_func` = 7 and `cpu_rst_mod` high clears every level i whose `cpu_lvl_mod[i]` is 1, on the edge that accepts it. If `cpu_rst_mod` is low, or the function is any other code, no level changes.
- R4: If a host raise (code 2) and a CPU sense-with-reset select the same level in the same cycle, that level ends up set.
- R5: Host command code 13 returns the levels held before the command in `host_rsp_data[2:0]`, with the upper bits zero, and clears all levels.
- R6: Every CPU command stores `cpu_func` in the function field. Host command code 5 returns the field as it was before the command in `host_rsp_data[2:0]` and clears it, so the field reads zero until the next CPU command. Repeating the same function after a poll therefore shows up again.
- R7: If a poll (code 5) and a CPU command fall in the same cycle, the response carries the older value and the field keeps the new function.
- R8: Host command code 1 copies `host_cmd_data[14:0]` into `cpu_dsw[14:0]`. If `host_cmd_data[15]` is 1 it sets the operation-complete flag, `cpu_dsw[15]`. A write with bit 15 at 0 leaves the flag as it was.
- R9: A CPU sense-with-reset clears the operation-complete flag. If a code 1 write with bit 15 set falls in the same cycle, the flag ends up set.
- R10: `host_rsp_valid` pulses for one cycle, in the cycle after each accepted host command. Code 6 returns `cpu_dsw` as it was before the command. Any other code not listed above returns zero and changes nothing. While `host_rsp_valid` is low, `host_rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cmd_valid | input | 1 | Host command present this cycle |
| host_cmd_code | input | 4 | Host command code |
| host_cmd_data | input | 16 | Host command operand |
| host_rsp_valid | output | 1 | Response strobe, one cycle after the command |
| host_rsp_data | output | 16 | Response value |
| cpu_cmd_valid | input | 1 | CPU device command present this cycle |
| cpu_func | input | 3 | CPU function code (7 = sense) |
| cpu_rst_mod | input | 1 | Reset modifier of the CPU command |
| cpu_lvl_mod | input | 3 | Level-select modifier bits |
| irq_req | output | 3 | Interrupt request, one bit per level |
| cpu_dsw | output | 16 | Device status word seen by the CPU, bit 15 = operation complete |

## Verification
The host and the CPU act on the same state, and three pairs of their actions can fall in one clock cycle. A host raise can meet a CPU sense-with-reset on the same level. A host status write with the completion bit can meet a CPU reset. A host function poll can meet a new CPU command. Directed steps drive each pair on the same edge, and a long stretch of random traffic on both ports repeats them. A behavioural model in the bench applies the priority rules (set wins, the new function wins, the response carries the older value). The bench compares every output against this model after each clock.

// File: rtl/dss_pkg.sv
// Package: shared command codes and sizes for the device status shadow.
// Assumes the host command code is 4 bits wide. Code values are fixed by
// the host software protocol.
package dss_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] OP_WR_STATUS = 4'd1;
    localparam logic [CODE_W-1:0] OP_RAISE     = 4'd2;
    localparam logic [CODE_W-1:0] OP_POLL_FUNC = 4'd5;
    localparam logic [CODE_W-1:0] OP_RD_STATUS = 4'd6;
    localparam logic [CODE_W-1:0] OP_FETCH_LVL = 4'd13;

    // One strobe per decoded host command.
    typedef struct packed {
        logic wr_status;
        logic raise;
        logic poll_func;
        logic rd_status;
        logic fetch_lvl;
    } host_op_t;
endpackage

// File: rtl/dss_host_decode.sv
// Host command decoder: turns a valid code into one-hot operation strobes.
// Assumes at most one command per cycle. Unknown codes produce no strobe.
module dss_host_decode
    import dss_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output host_op_t          op
);
    // Purpose: map the code to its strobe when a command is present.
    always_comb begin
        op           = '0;
        op.wr_status = cmd_valid && (cmd_code == OP_WR_STATUS);
        op.raise     = cmd_valid && (cmd_code == OP_RAISE);
        op.poll_func = cmd_valid && (cmd_code == OP_POLL_FUNC);
        op.rd_status = cmd_valid && (cmd_code == OP_RD_STATUS);
        op.fetch_lvl = cmd_valid && (cmd_code == OP_FETCH_LVL);
    end
endmodule

// File: rtl/dss_level_bank.sv
// Interrupt level bank: one flop per level. A set wins over a clear in the
// same cycle. Assumes set_mask and fetch_clr never come from the same host
// command.
module dss_level_bank #(
    parameter int NUM_LVL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] set_mask,
    input  logic [NUM_LVL-1:0] clr_mask,
    input  logic               clr_all,
    output logic [NUM_LVL-1:0] lvl
);
    for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_lvl
        // Purpose: hold one level with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl[gi] <= 1'b0;
            else if (set_mask[gi])
                lvl[gi] <= 1'b1;
            else if (clr_mask[gi] || clr_all)
                lvl[gi] <= 1'b0;
        end
    end
endmodule

// File: rtl/dss_flag.sv
// Set/clear flag used for the operation-complete bit. Set has priority so
// that a fresh completion is never lost to a reset in the same cycle.
module dss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Purpose: hold the flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/dss_func_latch.sv
// Function field: captures each CPU function code and is cleared by a host
// poll. A CPU load in the same cycle as a poll wins. The caller samples the
// pre-clear value for the response.
module dss_func_latch #(
    parameter int FUNC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FUNC_W-1:0] load_val,
    input  logic              clr,
    output logic [FUNC_W-1:0] func
);
    // Purpose: store the newest function, or clear it after a poll.
    always_ff @(posedge clk) begin
        if (!rst_n)
            func <= '0;
        else if (load)
            func <= load_val;
        else if (clr)
            func <= '0;
    end
endmodule

// File: rtl/dev_status_shadow.sv
// Device status and interrupt shadow for one virtual I/O device.
// Assumes one host command and one CPU command at most per cycle. All state
// uses a synchronous active-low reset. Host responses are registered and
// appear exactly one cycle after the command. They carry pre-update values.
module dev_status_shadow
    import dss_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_LVL    = 3,
    parameter int FUNC_W     = 3,
    parameter int SENSE_FUNC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cmd_valid,
    input  logic [3:0]        host_cmd_code,
    input  logic [DATA_W-1:0] host_cmd_data,
    output logic              host_rsp_valid,
    output logic [DATA_W-1:0] host_rsp_data,
    input  logic              cpu_cmd_valid,
    input  logic [FUNC_W-1:0] cpu_func,
    input  logic              cpu_rst_mod,
    input  logic [NUM_LVL-1:0] cpu_lvl_mod,
    output logic [NUM_LVL-1:0] irq_req,
    output logic [DATA_W-1:0] cpu_dsw
);
    localparam int OPC_BIT = DATA_W - 1;
    localparam logic [FUNC_W-1:0] SENSE_CODE = FUNC_W'(SENSE_FUNC);

    host_op_t           op;
    logic               sense_rst;
    logic [NUM_LVL-1:0] lvl;
    logic [NUM_LVL-1:0] raise_mask;
    logic [NUM_LVL-1:0] clr_mask;
    logic [FUNC_W-1:0]  func_q;
    logic               opc_q;
    logic [OPC_BIT-1:0] stat_q;
    logic [DATA_W-1:0]  rsp_next;
    logic               rsp_valid_q;
    logic [DATA_W-1:0]  rsp_data_q;

    dss_host_decode u_dec (
        .cmd_valid (host_cmd_valid),
        .cmd_code  (host_cmd_code),
        .op        (op)
    );

    // Purpose: qualify the CPU sense-with-reset and form the level masks.
    always_comb begin
        sense_rst  = cpu_cmd_valid && (cpu_func == SENSE_CODE) && cpu_rst_mod;
        clr_mask   = sense_rst ? cpu_lvl_mod : '0;
        raise_mask = op.raise ? host_cmd_data[NUM_LVL-1:0] : '0;
    end

    dss_level_bank #(.NUM_LVL(NUM_LVL)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (raise_mask),
        .clr_mask (clr_mask),
        .clr_all  (op.fetch_lvl),
        .lvl      (lvl)
    );

    dss_flag u_opc (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (op.wr_status && host_cmd_data[OPC_BIT]),
        .clr   (sense_rst),
        .flag  (opc_q)
    );

    dss_func_latch #(.FUNC_W(FUNC_W)) u_func (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cpu_cmd_valid),
        .load_val (cpu_func),
        .clr      (op.poll_func),
        .func     (func_q)
    );

    // Purpose: keep the host-written status bits other than completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (op.wr_status)
            stat_q <= host_cmd_data[OPC_BIT-1:0];
    end

    // Purpose: select the pre-update value that answers this host command.
    always_comb begin
        rsp_next = '0;
        if (op.fetch_lvl)
            rsp_next = {{(DATA_W-NUM_LVL){1'b0}}, lvl};
        else if (op.poll_func)
            rsp_next = {{(DATA_W-FUNC_W){1'b0}}, func_q};
        else if (op.rd_status)
            rsp_next = {opc_q, stat_q};
    end

    // Purpose: register the one-cycle response strobe and its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= host_cmd_valid;
            rsp_data_q  <= host_cmd_valid ? rsp_next : '0;
        end
    end

    assign irq_req        = lvl;
    assign cpu_dsw        = {opc_q, stat_q};
    assign host_rsp_valid = rsp_valid_q;
    assign host_rsp_data  = rsp_data_q;
endmodule

// File: rtl/dss_checker.sv
// Checker for dev_status_shadow: properties over its ports, attached by bind.
module dss_checker #(
    parameter int DATA_W  = 16,
    parameter int NUM_LVL = 3,
    parameter int FUNC_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_cmd_valid,
    input logic [3:0]         host_cmd_code,
    input logic [DATA_W-1:0]  host_cmd_data,
    input logic               host_rsp_valid,
    input logic [DATA_W-1:0]  host_rsp_data,
    input logic               cpu_cmd_valid,
    input logic [FUNC_W-1:0]  cpu_func,
    input logic               cpu_rst_mod,
    input logic [NUM_LVL-1:0] cpu_lvl_mod,
    input logic [NUM_LVL-1:0] irq_req,
    input logic [DATA_W-1:0]  cpu_dsw
);
    logic sense_rst;
    logic raise_cmd;
    logic opc_set;
    assign sense_rst = cpu_cmd_valid && cpu_rst_mod && (cpu_func == FUNC_W'(7));
    assign raise_cmd = host_cmd_valid && (host_cmd_code == 4'd2);
    assign opc_set   = host_cmd_valid && (host_cmd_code == 4'd1) && host_cmd_data[DATA_W-1];

    // R3: selected levels are gone one edge after the sense-with-reset.
    p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_rst && !raise_cmd) |=> ((irq_req & $past(cpu_lvl_mod)) == '0));

    // R4: a raise always shows, even against a reset of the same level.
    p_raise_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        raise_cmd |=> ((irq_req & $past(host_cmd_data[NUM_LVL-1:0]))
                       == $past(host_cmd_data[NUM_LVL-1:0])));

    // R5: fetch returns the old levels and leaves none pending.
    p_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_valid && host_cmd_code == 4'd13) |=>
            (irq_req == '0 && host_rsp_data[NUM_LVL-1:0] == $past(irq_req)));

    // R8 and R9: completion set wins; with neither set nor reset it holds.
    p_opc_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        opc_set |=> cpu_dsw[DATA_W-1]);
    p_opc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!opc_set && !sense_rst) |=> $stable(cpu_dsw[DATA_W-1]));

    // R10: one response strobe per command, in the next cycle only.
    p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_cmd_valid |=> host_rsp_valid);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cmd_valid |=> (!host_rsp_valid && host_rsp_data == '0));
endmodule

bind dev_status_shadow dss_checker #(
    .DATA_W  (DATA_W),
    .NUM_LVL (NUM_LVL),
    .FUNC_W  (FUNC_W)
) u_dss_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_cmd_valid (host_cmd_valid),
    .host_cmd_code  (host_cmd_code),
    .host_cmd_data  (host_cmd_data),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_data  (host_rsp_data),
    .cpu_cmd_valid  (cpu_cmd_valid),
    .cpu_func       (cpu_func),
    .cpu_rst_mod    (cpu_rst_mod),
    .cpu_lvl_mod    (cpu_lvl_mod),
    .irq_req        (irq_req),
    .cpu_dsw        (cpu_dsw)
);

// File: tb/tb_dev_status_shadow.sv
// Bench: behavioural model updated on every clock, outputs compared each cycle.
module tb_dev_status_shadow;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cmd_valid = 1'b0;
    logic [3:0]  host_cmd_code = '0;
    logic [15:0] host_cmd_data = '0;
    logic        host_rsp_valid;
    logic [15:0] host_rsp_data;
    logic        cpu_cmd_valid = 1'b0;
    logic [2:0]  cpu_func = '0;
    logic        cpu_rst_mod = 1'b0;
    logic [2:0]  cpu_lvl_mod = '0;
    logic [2:0]  irq_req;
    logic [15:0] cpu_dsw;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state.
    int m_lvl = 0, m_func = 0, m_opc = 0, m_stat = 0, m_rv = 0, m_rd = 0;

    always #5 clk = ~clk;

    dev_status_shadow dut (
        .clk(clk), .rst_n(rst_n),
        .host_cmd_valid(host_cmd_valid), .host_cmd_code(host_cmd_code),
        .host_cmd_data(host_cmd_data), .host_rsp_valid(host_rsp_valid),
        .host_rsp_data(host_rsp_data), .cpu_cmd_valid(cpu_cmd_valid),
        .cpu_func(cpu_func), .cpu_rst_mod(cpu_rst_mod),
        .cpu_lvl_mod(cpu_lvl_mod), .irq_req(irq_req), .cpu_dsw(cpu_dsw)
    );

    function automatic void chk(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    // Model one clock edge from the inputs present before it.
    task automatic model_edge();
        int hv, code, d, cv, f, rm, lm, sr, rsp, old_lvl, old_func, old_dsw;
        hv = host_cmd_valid; code = host_cmd_code; d = host_cmd_data;
        cv = cpu_cmd_valid; f = cpu_func; rm = cpu_rst_mod; lm = cpu_lvl_mod;
        old_lvl = m_lvl; old_func = m_func; old_dsw = m_opc * 32768 + m_stat;
        if (!rst_n) begin
            m_lvl = 0; m_func = 0; m_opc = 0; m_stat = 0; m_rv = 0; m_rd = 0;
            return;
        end
        sr = (cv && f == 7 && rm) ? 1 : 0;
        rsp = 0;
        if (sr) begin
            m_lvl = m_lvl & ~lm & 7;
            m_opc = 0;
        end
        if (hv) begin
            case (code)
                1: begin m_stat = d % 32768; if (d >= 32768) m_opc = 1; end
                2: m_lvl = m_lvl | (d & 7);
                5: begin rsp = old_func; m_func = 0; end
                6: rsp = old_dsw;
                13: begin rsp = old_lvl; m_lvl = 0; end
                default: ;
            endcase
        end
        if (cv) m_func = f;
        m_rv = hv;
        m_rd = hv ? rsp : 0;
    endtask

    // Apply one cycle of stimulus, then compare after the edge.
    task automatic cyc(string tag, bit hv, int code, int d, bit cv, int f, bit rm, int lm);
        host_cmd_valid = hv; host_cmd_code = 4'(code); host_cmd_data = 16'(d);
        cpu_cmd_valid = cv; cpu_func = 3'(f); cpu_rst_mod = rm; cpu_lvl_mod = 3'(lm);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "irq_req", int'(irq_req), m_lvl);
        chk(tag, "cpu_dsw", int'(cpu_dsw), m_opc * 32768 + m_stat);
        chk(tag, "rsp_valid", int'(host_rsp_valid), m_rv);
        chk(tag, "rsp_data", int'(host_rsp_data), m_rd);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        cyc("R1", 1, 2, 7, 1, 7, 0, 0);           // traffic under reset is ignored
        cyc("R1", 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1;
        idle("R1");
        // R2: raise levels.
        cyc("R2", 1, 2, 5, 0, 0, 0, 0);
        cyc("R2", 1, 2, 2, 0, 0, 0, 0);
        // R3: sense without modifier, other function with modifier: no change.
        cyc("R3", 0, 0, 0, 1, 7, 0, 7);
        cyc("R3", 0, 0, 0, 1, 3, 1, 7);
        cyc("R3", 0, 0, 0, 1, 7, 1, 1);           // clear level 0 only
        // R4: raise and reset on the same level in one cycle.
        cyc("R4", 1, 2, 2, 1, 7, 1, 6);
        // R5: fetch-and-clear, then fetch of nothing.
        cyc("R5", 1, 13, 0, 0, 0, 0, 0);
        cyc("R5", 1, 13, 0, 0, 0, 0, 0);
        // R6: poll, repeat same function, poll again, poll of empty field.
        cyc("R6", 0, 0, 0, 1, 4, 0, 0);
        cyc("R6", 1, 5, 0, 0, 0, 0, 0);
        cyc("R6", 1, 5, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 1, 4, 0, 0);
        cyc("R6", 1, 5, 0, 0, 0, 0, 0);
        // R7: poll meets new CPU command.
        cyc("R7", 0, 0, 0, 1, 2, 0, 0);
        cyc("R7", 1, 5, 0, 1, 6, 0, 0);
        cyc("R7", 1, 5, 0, 0, 0, 0, 0);
        // R8: status write with and without completion bit.
        cyc("R8", 1, 1, 16'h8123, 0, 0, 0, 0);
        cyc("R8", 1, 1, 16'h0456, 0, 0, 0, 0);
        cyc("R10", 1, 6, 0, 0, 0, 0, 0);
        // R9: CPU reset clears completion; collision keeps it set.
        cyc("R9", 0, 0, 0, 1, 7, 1, 0);
        cyc("R9", 1, 1, 16'h8001, 1, 7, 1, 7);
        cyc("R10", 1, 6, 0, 0, 0, 0, 0);
        // R10: unknown codes change nothing and answer zero.
        cyc("R10", 1, 9, 16'hffff, 0, 0, 0, 0);
        cyc("R10", 1, 0, 16'hffff, 0, 0, 0, 0);
        idle("R10");
        // Mixed random traffic on both sides.
        for (int i = 0; i < 3000; i++) begin
            int codes[6] = '{1, 2, 5, 6, 13, 11};
            cyc("mixed(R2,R3,R5,R6,R8,R9,R10)", 1'($urandom_range(0, 1)),
                codes[$urandom_range(0, 5)], int'($urandom_range(0, 65535)),
                1'($urandom_range(0, 1)), int'($urandom_range(5, 7)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule